// File: doc/BRIEF.md
# EEPROM Configuration Boot Scanner

This block loads a 13-byte configuration record from an external serial EEPROM when the device starts up. A short high pulse on `preset_i` starts a scan. The block asks an external I2C random-byte reader for one byte at a time. Each request carries a single EEPROM address and ends with a one-cycle completion strobe that brings back either the data byte or an acknowledge error. Each fetched byte also goes through an internal CRC-8 accumulator.

A record holds two protected regions. The first is the general settings at offsets 0 to 5, with their check byte at offset 6. The second is a counter preload value at offsets 7 to 11, with its check byte at offset 12. Both check bytes are stored bit-inverted, so an erased or all-zero part never looks valid. The block tries four candidate base addresses in a fixed order and accepts the first one whose two checks both pass.

Fetched bytes go into a shadow buffer first. The live configuration outputs change only when a whole record has been accepted. If no candidate is accepted, the active-low error output is asserted and the loaded flag is cleared. Both stay that way until a later preset pulse produces a good load.

Top module: `boot_scan`

## Requirements
- R1: After reset, `busy_o`=0, `rd_req_o`=0, `loaded_o`=0, `err_no`=1 and `cfg_o` is all zero.
- R2: A scan starts on the clock edge where `preset_i` is sampled low after being sampled high while idle. On the next cycle `busy_o`=1, `rd_req_o`=1 and `rd_addr_o`=0x00.
- R3: Every record byte is fetched with its own request, at base+0, base+1, and so on in ascending order. `rd_req_o` and `rd_addr_o` hold still until a cycle with `rd_done_i`=1 consumes the byte.
- R4: Candidate bases are tried in the order 0x00, 0x40, 0x80, 0xA0. The scan never uses more than these four.
- R5: Both checks use a CRC-8 with polynomial 0x2F, start value 0, most significant bit first. The check over offsets 0..5 must equal the bitwise inverse of the byte at offset 6. The check over offsets 7..11 must equal the bitwise inverse of the byte at offset 12.
- R6: The first check mismatch ends the candidate at once. The next read goes to offset 0 of the next base.
- R7: A completion with `rd_nack_i`=1 fails the candidate in the same way as a check mismatch.
- R8: When a record is accepted, `cfg_o[8k+7:8k]` holds the byte from offset k of that record. At the same time `loaded_o`=1, `err_no`=1 and `busy_o` returns to 0.
- R9: When all four candidates fail, `err_no`=0 and `loaded_o`=0, and `cfg_o` keeps its previous value. A later successful scan sets `err_no`=1 and `loaded_o`=1 again.
- R10: A preset pulse that arrives while a scan is running has no effect. The running scan continues with the same address sequence, and no second scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_i | input | 1 | Start pulse; the scan begins after it falls |
| rd_req_o | output | 1 | Byte read request to the I2C reader |
| rd_addr_o | output | 8 | EEPROM byte address of the pending request |
| rd_done_i | input | 1 | One-cycle completion strobe from the reader |
| rd_data_i | input | 8 | Byte read, valid with `rd_done_i` |
| rd_nack_i | input | 1 | Acknowledge error, valid with `rd_done_i` |
| busy_o | output | 1 | Scan in progress |
| loaded_o | output | 1 | A valid record has been loaded |
| err_no | output | 1 | Checksum failure, active low |
| cfg_o | output | 104 | Live configuration, byte k at bits 8k+7:8k |

## Verification
Some behaviours are checked by assertions on every cycle:
- a request never appears outside a scan, and its address stays stable while it waits;
- a scan always opens at the first base;
- the loaded flag never coexists with an asserted error;
- the live configuration changes only on the cycle a record is accepted;
- the CRC accumulator is zero after every clear.

Other behaviours only the directed scenarios can show:
- the exact order of addresses across candidates;
- early abort at the settings check and at the preload check;
- an acknowledge error in the middle of a record;
- an all-zero part being rejected because of the inverted check bytes;
- retention of old values after a failed scan, followed by recovery.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } scan_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/boot_crc8.sv
module boot_crc8 #(
  parameter logic [7:0] POLY = 8'h2F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc_step(crc_o, data_i);
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == 8'h00));
endmodule

// File: rtl/boot_rec_store.sv
module boot_rec_store #(
  parameter int REC_LEN = 13,
  localparam int OFF_W  = $clog2(REC_LEN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [OFF_W-1:0]       wr_idx_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   commit_i,
  output logic [REC_LEN*8-1:0]   live_o
);
  for (genvar k = 0; k < REC_LEN; k++) begin : g_byte
    logic [7:0] shadow_q;
    logic       hit;
    assign hit = wr_i && (wr_idx_i == OFF_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q        <= '0;
        live_o[k*8 +: 8] <= '0;
      end else begin
        if (hit) shadow_q <= wr_data_i;
        // last byte arrives in the commit cycle itself
        if (commit_i) live_o[k*8 +: 8] <= hit ? wr_data_i : shadow_q;
      end
    end
  end
endmodule

// File: rtl/boot_scan.sv
module boot_scan #(
  parameter int ADDR_W      = 8,
  parameter int REC_LEN     = 13,
  parameter int SET_CRC_OFF = 6,
  parameter int NUM_BASES   = 4,
  parameter logic [NUM_BASES*ADDR_W-1:0] BASES = {8'hA0, 8'h80, 8'h40, 8'h00},
  parameter logic [7:0] POLY = 8'h2F
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  preset_i,
  output logic                  rd_req_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic                  rd_done_i,
  input  logic [7:0]            rd_data_i,
  input  logic                  rd_nack_i,
  output logic                  busy_o,
  output logic                  loaded_o,
  output logic                  err_no,
  output logic [REC_LEN*8-1:0]  cfg_o
);
  import boot_pkg::*;

  localparam int OFF_W = $clog2(REC_LEN);
  localparam int IDX_W = (NUM_BASES > 1) ? $clog2(NUM_BASES) : 1;
  localparam logic [OFF_W-1:0] OFF_A    = OFF_W'(SET_CRC_OFF);
  localparam logic [OFF_W-1:0] OFF_B    = OFF_W'(REC_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BASES - 1);

  scan_state_e      state_q;
  logic [IDX_W-1:0] base_q;
  logic [OFF_W-1:0] off_q;
  logic             preset_q;
  logic [7:0]       crc_q;

  logic start, take, is_a, is_b, crc_bad, cand_fail, rec_ok, last_base;

  assign start     = preset_q && !preset_i && (state_q == ST_IDLE);
  assign take      = (state_q == ST_READ) && rd_done_i;
  assign is_a      = (off_q == OFF_A);
  assign is_b      = (off_q == OFF_B);
  assign crc_bad   = (is_a || is_b) && (crc_q != ~rd_data_i);
  assign cand_fail = take && (rd_nack_i || crc_bad);
  assign rec_ok    = take && !cand_fail && is_b;
  assign last_base = (base_q == IDX_LAST);

  assign rd_req_o  = (state_q == ST_READ);
  assign busy_o    = (state_q != ST_IDLE);
  assign rd_addr_o = BASES[base_q*ADDR_W +: ADDR_W] + ADDR_W'(off_q);

  boot_crc8 #(.POLY(POLY)) i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start || cand_fail || (take && is_a)),
    .en_i   (take && !is_a && !is_b),
    .data_i (rd_data_i),
    .crc_o  (crc_q)
  );

  boot_rec_store #(.REC_LEN(REC_LEN)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (take && !rd_nack_i),
    .wr_idx_i  (off_q),
    .wr_data_i (rd_data_i),
    .commit_i  (rec_ok),
    .live_o    (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      off_q    <= '0;
      preset_q <= 1'b0;
      loaded_o <= 1'b0;
      err_no   <= 1'b1;
    end else begin
      preset_q <= preset_i;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_READ;
          base_q  <= '0;
          off_q   <= '0;
        end
        ST_READ: if (take) begin
          if (cand_fail) begin
            off_q <= '0;
            if (last_base) begin
              state_q  <= ST_IDLE;
              loaded_o <= 1'b0;
              err_no   <= 1'b0;
            end else begin
              base_q <= base_q + IDX_W'(1);
            end
          end else if (rec_ok) begin
            state_q  <= ST_IDLE;
            loaded_o <= 1'b1;
            err_no   <= 1'b1;
          end else begin
            off_q <= off_q + OFF_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
  // R3, R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_done_i) |=> (rd_req_o && $stable(rd_addr_o)));
  // R2
  start_first_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (rd_req_o && rd_addr_o == BASES[ADDR_W-1:0]));
  // R8
  loaded_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |-> err_no);
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_ok |=> $stable(cfg_o));
endmodule

// File: tb/test_boot_scan.sv
module test_boot_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preset = 1'b0;
  logic rd_req, rd_done = 1'b0, rd_nack = 1'b0;
  logic [7:0] rd_addr, rd_data = '0;
  logic busy, loaded, err_n;
  logic [103:0] cfg;

  int checks = 0, failures = 0;
  logic [7:0] mem [256];
  logic       nack_at [256];
  logic [7:0] log_a [512];
  int         log_n = 0;
  logic [7:0] exp_a [512];
  int         exp_n = 0;

  always #2 clk = ~clk;

  boot_scan i_boot_scan (
    .clk_i(clk), .rst_ni(rst_n), .preset_i(preset),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_done_i(rd_done),
    .rd_data_i(rd_data), .rd_nack_i(rd_nack),
    .busy_o(busy), .loaded_o(loaded), .err_no(err_n), .cfg_o(cfg)
  );

  // byte reader model: answers each request after a short latency
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      rd_done = 1'b0;
      if (rd_req) begin
        if (lat == 2) begin
          rd_done = 1'b1;
          rd_data = mem[rd_addr];
          rd_nack = nack_at[rd_addr];
          if (log_n < 512) log_a[log_n] = rd_addr;
          log_n++;
          lat = 0;
        end else lat++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[7] ^ d[i]) ? ({r[6:0], 1'b0} ^ 8'h2F) : {r[6:0], 1'b0};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; nack_at[i] = 1'b0; end
  endtask

  task automatic put_rec(input int base, input int seed, input bit bad_a, input bit bad_b);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 6; k++) begin
      mem[base+k] = 8'(seed + 37*k + 5);
      c = crc8(c, mem[base+k]);
    end
    mem[base+6] = ~c ^ {7'd0, bad_a};
    c = 8'h00;
    for (int k = 7; k < 12; k++) begin
      mem[base+k] = 8'(seed * 3 + 11*k + 1);
      c = crc8(c, mem[base+k]);
    end
    mem[base+12] = ~c ^ {7'd0, bad_b};
  endtask

  function automatic logic [103:0] rec_of(input int base);
    logic [103:0] v;
    for (int k = 0; k < 13; k++) v[k*8 +: 8] = mem[base+k];
    return v;
  endfunction

  task automatic exp_range(input int base, input int n);
    for (int k = 0; k < n; k++) begin exp_a[exp_n] = 8'(base + k); exp_n++; end
  endtask

  task automatic run_scan(input string req);
    log_n = 0;
    @(negedge clk); preset = 1'b1;
    @(negedge clk); preset = 1'b0;
    @(negedge clk);
    chk(busy && rd_req && rd_addr == 8'h00, req, "scan start busy/req/addr",
        {busy, rd_req, rd_addr}, {1'b1, 1'b1, 8'h00});
    while (busy) @(negedge clk);
  endtask

  task automatic chk_log(input string req);
    bit ok = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) if (log_a[i] != exp_a[i]) ok = 0;
    chk(ok, req, "address sequence (count)", 128'(log_n), 128'(exp_n));
    exp_n = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !rd_req, "R1", "idle after reset", {busy, rd_req}, 0);
    chk(!loaded && err_n, "R1", "loaded/err_n after reset", {loaded, err_n}, 2'b01);
    chk(cfg == '0, "R1", "cfg after reset", cfg, 0);
  endtask

  task automatic t_first_base();
    clear_mem(); put_rec(8'h00, 3, 0, 0);
    run_scan("R2");
    exp_range(8'h00, 13); chk_log("R3");
    chk(cfg == rec_of(8'h00), "R8", "cfg from base 0x00", cfg, rec_of(8'h00));
    chk(loaded && err_n, "R8", "loaded/err_n", {loaded, err_n}, 2'b11);
  endtask

  task automatic t_settings_crc_bad();
    clear_mem(); put_rec(8'h00, 9, 1, 0); put_rec(8'h40, 21, 0, 0);
    run_scan("R6");
    exp_range(8'h00, 7); exp_range(8'h40, 13); chk_log("R6");
    chk(cfg == rec_of(8'h40), "R5", "cfg from base 0x40", cfg, rec_of(8'h40));
  endtask

  task automatic t_mixed();
    clear_mem();
    put_rec(8'h00, 4, 0, 1); put_rec(8'h40, 5, 0, 0);
    nack_at[8'h43] = 1'b1;
    put_rec(8'h80, 6, 1, 0); put_rec(8'hA0, 77, 0, 0);
    run_scan("R4");
    exp_range(8'h00, 13); exp_range(8'h40, 4); exp_range(8'h80, 7); exp_range(8'hA0, 13);
    chk_log("R4 R7");
    chk(cfg == rec_of(8'hA0), "R4", "cfg from base 0xA0", cfg, rec_of(8'hA0));
    chk(loaded && err_n, "R7", "loaded/err_n", {loaded, err_n}, 2'b11);
  endtask

  task automatic t_all_zero();
    logic [103:0] prev = cfg;
    clear_mem();
    run_scan("R9");
    exp_range(8'h00, 7); exp_range(8'h40, 7); exp_range(8'h80, 7); exp_range(8'hA0, 7);
    chk_log("R5");
    chk(!loaded && !err_n, "R9", "loaded/err_n after fail", {loaded, err_n}, 2'b00);
    chk(cfg == prev, "R9", "cfg retained", cfg, prev);
    chk(!busy && !rd_req, "R4", "no fifth base", {busy, rd_req}, 0);
  endtask

  task automatic t_recover();
    clear_mem(); put_rec(8'h80, 55, 0, 0);
    run_scan("R9");
    exp_range(8'h00, 7); exp_range(8'h40, 7); exp_range(8'h80, 13); chk_log("R9");
    chk(loaded && err_n, "R9", "recovered loaded/err_n", {loaded, err_n}, 2'b11);
    chk(cfg == rec_of(8'h80), "R8", "cfg from base 0x80", cfg, rec_of(8'h80));
  endtask

  task automatic t_preset_busy();
    clear_mem(); put_rec(8'h00, 99, 0, 0);
    log_n = 0;
    @(negedge clk); preset = 1'b1;
    @(negedge clk); preset = 1'b0;
    repeat (10) @(negedge clk);
    preset = 1'b1;
    @(negedge clk); preset = 1'b0;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!busy && !rd_req, "R10", "no second scan", {busy, rd_req}, 0);
    exp_range(8'h00, 13); chk_log("R10");
    chk(cfg == rec_of(8'h00), "R10", "cfg", cfg, rec_of(8'h00));
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_base();
    t_settings_crc_bad();
    t_mixed();
    t_all_zero();
    t_recover();
    t_preset_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule